// File: doc/BRIEF.md
# Direct Digital Synthesis PWM Waveform Generator

This block produces a periodic waveform on a single digital pin. A 24-bit phase accumulator adds a programmable step once per PWM frame. The upper byte of the phase addresses a 256-point waveform, and the sample at that address becomes the duty value of a 256-clock PWM frame. A low-pass filter outside the block turns the pin back into an analog signal. The output frequency is step × Fframe / 2^24. With a 32 MHz clock the frame rate is 125 kHz, so a step of 1342177 gives close to 10 kHz.

A host changes the step and the waveform shape while the block runs. It presents both values with a one-cycle load strobe. The values wait in a shadow register and take effect together at the next frame boundary, so no frame mixes old and new settings. The duty value for a frame is computed and registered during the frame before it.

Top module: `dds_pwm_gen`

## Requirements
- R1: Reset is synchronous and active low. It clears the phase, the frame counter and the duty value, selects the sine shape with a step of zero, and holds the PWM pin low with no frame-start pulse. The first frame after reset has duty 0.
- R2: A frame is 256 clocks long. With duty D the pin is high in the first D clocks of the frame and low in the rest. Duty 0 never goes high, and duty 255 is high for 255 of the 256 clocks.
- R3: The frame-start output is high for exactly one clock, the first clock of each frame, every 256 clocks. It does not pulse at the start of the first frame after reset.
- R4: At each frame end the 24-bit phase adds the active step, modulo 2^24. The duty of frame j+1 is the waveform value at the phase's top 8 bits as they stood during frame j.
- R5: When load_i is high, step_i and wave_i are captured into a shadow register, and the last load before a boundary wins. The shadow values become active at the next frame end, and that boundary's phase addition already uses the new step. A load in the final clock of a frame waits for the following frame end.
- R6: Shape code 1 (square) gives 255 for addresses below 128 and 0 otherwise. Code 2 (sawtooth) gives the address itself. Code 3 (triangle) gives 2a for a below 128 and 511 − 2a otherwise.
- R7: Shape code 0 (sine) gives round(128 + 127·sin(2π·a/256)).
- R8: The duty value never changes inside a frame. A load or an input change in the middle of a frame leaves that frame's high time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Strobe that captures step_i and wave_i into the shadow register |
| step_i | input | 24 | Phase step added once per frame |
| wave_i | input | 2 | Shape code: 0 sine, 1 square, 2 sawtooth, 3 triangle |
| pwm_o | output | 1 | PWM output |
| frame_start_o | output | 1 | One-clock pulse in the first clock of each frame |

## Verification
The hardest case to reach from the ports is a load in the final clock of a frame. In that case the shadow value already pending is applied, and the new one has to wait a full frame. The bench reaches this clock by counting: it waits for a frame-start pulse, steps 255 clocks and raises the strobe. It then checks per-frame high times that tell a one-frame deferral apart from an immediate pickup. A second case drives two loads inside one frame to confirm that the last one wins. A full sweep of the 256 sine points, with a wrap of the phase back to zero, covers the computed sine table.

// File: rtl/dds_pwm_pkg.sv
// Shared types for the DDS PWM generator.
// Assumes: shape codes are fixed by the host interface (0 sine .. 3 triangle).
package dds_pwm_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_SAW    = 2'd2,
        WAVE_TRI    = 2'd3
    } wave_e;

endpackage

// File: rtl/dds_phase_ctrl.sv
// Phase accumulator with shadowed step and shape settings.
// Does: captures host loads into a shadow register and moves them to the
//       active settings at a frame end; advances the phase once per frame.
// Assumes: frame_end_i is high for exactly one clock per frame.
module dds_phase_ctrl
    import dds_pwm_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W-1:0]  step_i,
    input  wave_e             wave_i,
    input  logic              frame_end_i,
    output logic [ADDR_W-1:0] addr_o,
    output wave_e             wave_o
);

    logic [ACC_W-1:0] step_sh;
    wave_e            wave_sh;
    logic             pend_q;
    logic [ACC_W-1:0] step_act;
    wave_e            wave_act;
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] step_use;

    // Step that applies at this boundary: the pending shadow value wins.
    assign step_use = pend_q ? step_sh : step_act;

    // Shadow capture; a load always overwrites, a boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_sh <= '0;
            wave_sh <= WAVE_SINE;
            pend_q  <= 1'b0;
        end else if (load_i) begin
            step_sh <= step_i;
            wave_sh <= wave_i;
            pend_q  <= 1'b1;
        end else if (frame_end_i) begin
            pend_q  <= 1'b0;
        end
    end

    // Active settings move over only at a frame end with a pending load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_act <= '0;
            wave_act <= WAVE_SINE;
        end else if (frame_end_i && pend_q) begin
            step_act <= step_sh;
            wave_act <= wave_sh;
        end
    end

    // Phase advance, once per frame, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (frame_end_i) begin
            phase_q <= phase_q + step_use;
        end
    end

    assign addr_o = phase_q[ACC_W-1 -: ADDR_W];
    assign wave_o = wave_act;

endmodule

// File: rtl/dds_wave_shaper.sv
// Waveform lookup: maps a phase address and shape code to a duty value.
// Does: builds the sine table at elaboration from a series expansion,
//       derives square, sawtooth and triangle arithmetically, and
//       registers the selected value.
// Assumes: DW >= 2; the consumer samples duty_o only at a frame end.
module dds_wave_shaper
    import dds_pwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] addr_i,
    input  wave_e         wave_i,
    output logic [DW-1:0] duty_o
);

    localparam int  TBL   = 1 << DW;
    localparam int  MID   = 1 << (DW - 1);
    localparam int  AMP   = MID - 1;
    localparam int  TERMS = 20;
    localparam real TWO_PI = 6.283185307179586;

    // Rounded sine sample for table index n, computed by Taylor series.
    function automatic int sine_point(input int n);
        real x;
        real term;
        real sum;
        real v;
        x = TWO_PI * real'(n) / real'(TBL);
        if (n >= TBL / 2) begin
            x = x - TWO_PI;
        end
        term = x;
        sum  = x;
        for (int k = 1; k <= TERMS; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        v = real'(MID) + real'(AMP) * sum;
        return $rtoi(v + 0.5);
    endfunction

    logic [DW-1:0] sine_rom [TBL];

    for (genvar i = 0; i < TBL; i++) begin : g_sine
        localparam int PT = sine_point(i);
        assign sine_rom[i] = PT[DW-1:0];
    end

    logic [DW-1:0] sq_val;
    logic [DW-1:0] saw_val;
    logic [DW-1:0] tri_val;
    logic [DW-1:0] pick;

    // Arithmetic shapes derived from the address byte.
    always_comb begin
        sq_val  = addr_i[DW-1] ? '0 : '1;
        saw_val = addr_i;
        tri_val = {addr_i[DW-2:0], 1'b0} ^ {DW{addr_i[DW-1]}};
    end

    // Shape selection.
    always_comb begin
        case (wave_i)
            WAVE_SINE:   pick = sine_rom[addr_i];
            WAVE_SQUARE: pick = sq_val;
            WAVE_SAW:    pick = saw_val;
            WAVE_TRI:    pick = tri_val;
            default:     pick = '0;
        endcase
    end

    // Registered next-frame duty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o <= '0;
        end else begin
            duty_o <= pick;
        end
    end

endmodule

// File: rtl/dds_pwm_frame.sv
// PWM frame engine: free-running frame counter, per-frame duty latch,
// output compare and frame-start pulse.
// Assumes: duty_next_i is stable in the last clock of a frame.
module dds_pwm_frame #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] duty_next_i,
    output logic          pwm_o,
    output logic          start_o,
    output logic          frame_end_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] duty_o
);

    localparam logic [DW-1:0] CNT_LAST = '1;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] duty_q;
    logic          start_q;

    assign frame_end_o = (cnt_q == CNT_LAST);

    // Frame position counter, wraps every 2^DW clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Duty latch, updated only at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (frame_end_o) begin
            duty_q <= duty_next_i;
        end
    end

    // Frame-start pulse in the clock after each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= frame_end_o;
        end
    end

    assign pwm_o   = (cnt_q < duty_q);
    assign start_o = start_q;
    assign cnt_o   = cnt_q;
    assign duty_o  = duty_q;

endmodule

// File: rtl/dds_pwm_gen.sv
// Top of the DDS PWM waveform generator.
// Does: ties the phase control, waveform shaper and PWM frame engine
//       together. One phase step per frame, one duty value per frame.
// Assumes: the host holds step_i and wave_i valid while load_i is high.
module dds_pwm_gen
    import dds_pwm_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W-1:0]  step_i,
    input  logic [1:0]        wave_i,
    output logic              pwm_o,
    output logic              frame_start_o
);

    logic [DUTY_W-1:0] phase_addr;
    wave_e             wave_act;
    logic [DUTY_W-1:0] duty_next;
    logic [DUTY_W-1:0] duty_cur;
    logic [DUTY_W-1:0] frame_cnt;
    logic              frame_end;

    dds_phase_ctrl #(
        .ACC_W  (ACC_W),
        .ADDR_W (DUTY_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .step_i      (step_i),
        .wave_i      (wave_e'(wave_i)),
        .frame_end_i (frame_end),
        .addr_o      (phase_addr),
        .wave_o      (wave_act)
    );

    dds_wave_shaper #(
        .DW (DUTY_W)
    ) u_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (phase_addr),
        .wave_i (wave_act),
        .duty_o (duty_next)
    );

    dds_pwm_frame #(
        .DW (DUTY_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_next_i (duty_next),
        .pwm_o       (pwm_o),
        .start_o     (frame_start_o),
        .frame_end_o (frame_end),
        .cnt_o       (frame_cnt),
        .duty_o      (duty_cur)
    );

endmodule

// File: rtl/dds_pwm_gen_chk.sv
// Assertion checker for dds_pwm_gen, attached by bind.
// Assumes: cnt, addr and duty are the frame counter, phase address and
//          latched duty of the bound instance.
module dds_pwm_gen_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwm_o,
    input logic          start_o,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] addr,
    input logic [DW-1:0] duty
);

    localparam logic [DW-1:0] LAST = '1;

    // R1: the clock after a reset edge shows a quiet output.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pwm_o && !start_o));

    // R3: a start pulse only in the first clock of a frame.
    a_r3_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cnt == '0));

    // R3: a start pulse lasts one clock.
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R2: once low inside a frame, the pin stays low until the frame ends.
    a_r2_no_regrow: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_o && cnt != LAST) |=> !pwm_o);

    // R4: the phase address moves only across a frame end.
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> $stable(addr));

    // R8: the latched duty moves only across a frame end.
    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> $stable(duty));

endmodule

bind dds_pwm_gen dds_pwm_gen_chk #(.DW(DUTY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_o   (pwm_o),
    .start_o (frame_start_o),
    .cnt     (frame_cnt),
    .addr    (phase_addr),
    .duty    (duty_cur)
);

// File: tb/dds_pwm_gen_tb_top.sv
// Testbench: behavioural cycle model compared on every clock, plus
// per-frame high-time checks against closed-form expected duties.
module dds_pwm_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [23:0] step_i = '0;
    logic [1:0]  wave_i = '0;
    logic        pwm_o;
    logic        frame_start_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dds_pwm_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_i),
        .step_i        (step_i),
        .wave_i        (wave_i),
        .pwm_o         (pwm_o),
        .frame_start_o (frame_start_o)
    );

    // Expected waveform value from the requirement formulas (R6, R7).
    function automatic int wave_exp(input int a, input int w);
        case (w)
            0: return $rtoi(128.0 + 127.0 * $sin(6.283185307179586 * a / 256.0) + 0.5);
            1: return (a < 128) ? 255 : 0;
            2: return a;
            default: return (a < 128) ? 2 * a : 511 - 2 * a;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference model.
    int m_cnt = 0, m_acc = 0, m_duty = 0, m_dnext = 0;
    int m_step = 0, m_wave = 0, m_start = 0;
    int q_step[$];
    int q_wave[$];

    always @(posedge clk) begin
        int fe;
        int nd;
        if (!rst_n) begin
            m_cnt = 0; m_acc = 0; m_duty = 0; m_dnext = 0;
            m_step = 0; m_wave = 0; m_start = 0;
            q_step.delete(); q_wave.delete();
        end else begin
            fe = (m_cnt == 255) ? 1 : 0;
            nd = wave_exp((m_acc >> 16) & 255, m_wave);
            if (fe == 1) begin
                m_duty = m_dnext;
                if (q_step.size() > 0) begin
                    m_step = q_step.pop_front();
                    m_wave = q_wave.pop_front();
                end
                m_acc = (m_acc + m_step) & 32'h00FF_FFFF;
            end
            if (load_i) begin
                q_step.delete(); q_wave.delete();
                q_step.push_back(int'(step_i));
                q_wave.push_back(int'(wave_i));
            end
            m_start = fe;
            m_cnt   = (m_cnt + 1) % 256;
            m_dnext = nd;
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(rst_n ? "R2 pwm vs model" : "R1 pwm in reset",
                int'(pwm_o), (m_cnt < m_duty) ? 1 : 0);
            chk(rst_n ? "R3 start vs model" : "R1 start in reset",
                int'(frame_start_o), m_start);
        end
    end

    // Per-frame high-time history; hist[j] is the high count of frame j.
    int hist[$];
    int hi = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            hist.delete();
            hi = 0;
        end else if (frame_start_o) begin
            hist.push_back(hi);
            hi = int'(pwm_o);
        end else begin
            hi += int'(pwm_o);
        end
    end

    task automatic reset_dut();
        rst_n = 1'b0;
        load_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_load(input logic [23:0] s, input logic [1:0] w);
        load_i = 1'b1;
        step_i = s;
        wave_i = w;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_hist(input int n);
        while (hist.size() <= n) @(negedge clk);
    endtask

    task automatic wait_start();
        do @(negedge clk); while (!frame_start_o);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // T1: sawtooth, one address per frame.
        reset_dut();
        chk("R1 pwm low after reset", int'(pwm_o), 0);
        chk("R1 no start after reset", int'(frame_start_o), 0);
        do_load(24'h010000, 2'd2);
        wait_hist(12);
        chk("R1 first frame duty 0", hist[0], 0);
        chk("R7 reset shape sine at 0", hist[1], 128);
        for (int j = 2; j <= 12; j++) chk("R6 R4 sawtooth duty", hist[j], j - 1);

        // T2: full sine sweep with wrap, then reset while high.
        reset_dut();
        do_load(24'h010000, 2'd0);
        wait_hist(258);
        for (int j = 1; j <= 258; j++) chk("R7 R4 sine duty", hist[j], wave_exp((j - 1) % 256, 0));
        chk("R2 duty 255 high count", hist[65], 255);
        chk("R4 wrap back to address 0", hist[257], 128);
        while (!pwm_o) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset forces pwm low", int'(pwm_o), 0);
        chk("R1 reset no start", int'(frame_start_o), 0);

        // T3: square with half-turn step.
        reset_dut();
        do_load(24'h800000, 2'd1);
        wait_hist(8);
        for (int j = 2; j <= 8; j++) chk("R6 R2 square duty", hist[j], ((j - 1) % 2 == 0) ? 255 : 0);

        // T4: triangle, 16 addresses per frame.
        reset_dut();
        do_load(24'h100000, 2'd3);
        wait_hist(20);
        for (int j = 2; j <= 20; j++) chk("R6 triangle duty", hist[j], wave_exp(((j - 1) * 16) % 256, 3));

        // T5: two loads mid-frame, last wins, current frame untouched.
        reset_dut();
        wait_start();
        repeat (100) @(negedge clk);
        do_load(24'h300000, 2'd3);
        do_load(24'h010000, 2'd2);
        wait_hist(4);
        chk("R8 frame unchanged by load", hist[1], 128);
        chk("R8 next frame from old setting", hist[2], 128);
        chk("R5 last load wins", hist[3], 1);
        chk("R5 step applied", hist[4], 2);

        // T6: load in the final clock of a frame is deferred one frame.
        reset_dut();
        wait_start();
        repeat (255) @(negedge clk);
        do_load(24'h010000, 2'd2);
        wait_hist(4);
        chk("R5 boundary load not yet active", hist[3], 128);
        chk("R5 boundary load active one frame later", hist[4], 1);

        finish_run();
    end

endmodule